// File: doc/BRIEF.md
# Scoreboard Issue Control

This block decides, one cycle at a time, whether the next instruction in program order may enter execution. Execution is spread over three functional units with different latencies: a two-cycle adder, a four-cycle multiplier and an eight-cycle divider. Results may therefore finish out of order. The block tracks one reservation bit per architectural register and knows how busy each unit is. It raises `in_ready` only when the instruction's unit can accept it and none of its three registers has a result still pending. Read-after-write, write-after-write and structural hazards are all resolved at the point of issue.

Finished results compete for one shared register write port. Each cycle the port goes to the oldest instruction that has finished. A unit that loses keeps its result and holds its pipeline until the port is free. The requester presents one instruction at a time and keeps it steady until it is accepted, so order is kept without any queue inside the block.

Top module: `sb_issue_ctrl`

## Requirements
- R1: `in_ready` is never high while `in_valid` is low. An instruction is issued in exactly those cycles where both are high.
- R2: Opcode codes 0 and 1 use the add unit, code 2 the multiply unit and code 3 the divide unit. `wb_unit` reports 0 for add, 1 for multiply and 2 for divide.
- R3: An instruction is held while the reservation bit of its first source, its second source or its destination register is set.
- R4: Issuing an instruction reserves its destination register. A write-back clears that reservation at the end of its cycle, so a dependent instruction can issue in the following cycle at the earliest.
- R5: When the write port is uncontended, an instruction issued in cycle c writes back in cycle c+2 on the add unit, c+4 on the multiply unit and c+8 on the divide unit.
- R6: The add and multiply units are pipelined and accept a new, independent instruction in every cycle in which they are not stalled.
- R7: The divide unit is not pipelined. It holds a new divide from the cycle it accepts one up to and including that divide's write-back cycle.
- R8: At most one write-back happens per cycle. When several units have finished, the oldest issued instruction wins. The others keep their results and write back later in issue order.
- R9: A pipelined unit whose finished result is waiting for the write port refuses new instructions in that cycle.
- R10: After reset no register is reserved, every unit is idle, `wb_valid` is low and any valid instruction is accepted at once. Work in flight before a reset never writes back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | Opcode: 0/1 add, 2 multiply, 3 divide |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| in_dst | input | RW | Destination register |
| in_ready | output | 1 | Presented instruction issues this cycle |
| wb_valid | output | 1 | Write port is used this cycle |
| wb_unit | output | 2 | Unit that owns the write port |
| wb_dst | output | RW | Register written this cycle |

## Verification
The assertions assume that the requester holds an instruction unchanged until `in_ready` accepts it. They also assume that register indices stay below the register count. The bench drives each instruction from a task that changes the inputs only on the falling edge after an acceptance. It uses only indices 0 to 15. The ordering checks depend on issue tags staying unambiguous, which the tag width guarantees for any legal stream. The stimulus forces two-way and three-way write-port collisions so that the aging comparison and the stall paths are actually exercised.

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int NREG    = 16,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 4,
  parameter int LAT_DIV = 8,
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_src_a,
  input  logic [RW-1:0] in_src_b,
  input  logic [RW-1:0] in_dst,
  output logic          in_ready,
  output logic          wb_valid,
  output logic [1:0]    wb_unit,
  output logic [RW-1:0] wb_dst
);
  localparam int SEQW = $clog2(2 * (LAT_ADD + LAT_MUL + LAT_DIV)) + 1;
  localparam int CW   = $clog2(LAT_DIV) + 1;
  localparam logic [1:0] U_ADD = 2'd0, U_MUL = 2'd1, U_DIV = 2'd2;

  logic [NREG-1:0]           resv_q;
  logic [SEQW-1:0]           seq_q;
  logic [2:0]                fin_v, grant;
  logic [2:0][RW-1:0]        fin_d;
  logic [2:0][SEQW-1:0]      fin_s;
  logic [1:0]                stall;
  logic [1:0]                need_unit;
  logic                      unit_busy, hazard, go;
  logic                      div_v;
  logic [CW-1:0]             div_cnt;
  logic [RW-1:0]             div_d;
  logic [SEQW-1:0]           div_s;

  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] diff;
    diff = a - b;
    return diff[SEQW-1];
  endfunction

  assign need_unit = (in_op == 2'd3) ? U_DIV : (in_op == 2'd2) ? U_MUL : U_ADD;
  assign unit_busy = (need_unit == U_DIV) ? div_v : stall[need_unit[0]];
  assign hazard    = resv_q[in_src_a] | resv_q[in_src_b] | resv_q[in_dst];
  assign in_ready  = in_valid & ~unit_busy & ~hazard;
  assign go        = in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= '0;
    else if (go) seq_q <= seq_q + 1'b1;
  end

  for (genvar u = 0; u < 2; u++) begin : g_pipe
    localparam int L = (u == 0) ? LAT_ADD : LAT_MUL;
    logic [L-1:0]    v_q;
    logic [RW-1:0]   d_q [L];
    logic [SEQW-1:0] s_q [L];
    logic            take;

    assign take     = go && (need_unit == 2'(u));
    assign stall[u] = v_q[L-1] & ~grant[u];
    assign fin_v[u] = v_q[L-1];
    assign fin_d[u] = d_q[L-1];
    assign fin_s[u] = s_q[L-1];

    always_ff @(posedge clk) begin
      if (!rst_n) v_q <= '0;
      else if (!stall[u]) begin
        for (int k = L - 1; k > 0; k--) v_q[k] <= v_q[k-1];
        v_q[0] <= take;
      end
    end

    always_ff @(posedge clk) begin
      if (!stall[u]) begin
        for (int k = L - 1; k > 0; k--) begin
          d_q[k] <= d_q[k-1];
          s_q[k] <= s_q[k-1];
        end
        d_q[0] <= in_dst;
        s_q[0] <= seq_q;
      end
    end

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[L-1] && !grant[u]) |=> (v_q[L-1] && $stable(s_q[L-1])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_v   <= 1'b0;
      div_cnt <= '0;
    end else if (go && need_unit == U_DIV) begin
      div_v   <= 1'b1;
      div_cnt <= CW'(LAT_DIV - 1);
    end else if (div_v) begin
      if (div_cnt != '0) div_cnt <= div_cnt - 1'b1;
      else if (grant[2]) div_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (go && need_unit == U_DIV) begin
      div_d <= in_dst;
      div_s <= seq_q;
    end
  end

  assign fin_v[2] = div_v && (div_cnt == '0);
  assign fin_d[2] = div_d;
  assign fin_s[2] = div_s;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      grant[i] = fin_v[i];
      for (int j = 0; j < 3; j++)
        if (j != i && fin_v[j] && !older(fin_s[i], fin_s[j])) grant[i] = 1'b0;
    end
  end

  assign wb_valid = |grant;

  always_comb begin
    wb_unit = '0;
    wb_dst  = '0;
    for (int i = 0; i < 3; i++)
      if (grant[i]) begin
        wb_unit = 2'(i);
        wb_dst  = fin_d[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resv_q <= '0;
    else resv_q <= (resv_q & ~(wb_valid ? (NREG'(1) << wb_dst) : '0))
                 | (go ? (NREG'(1) << in_dst) : '0);
  end

  assert_wb_was_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> resv_q[wb_dst]);
  assert_issue_reserves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> resv_q[$past(in_dst)]);
  assert_wb_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !resv_q[$past(wb_dst)]);
  assert_div_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_op == 2'd3) |=> !(in_ready && in_op == 2'd3));
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_stalled_unit_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall[0] && in_valid && need_unit == U_ADD) |-> !in_ready);
endmodule

// File: tb/test_sb_issue_ctrl.sv
`timescale 1ns/1ps
module test_sb_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic       in_ready, wb_valid;
  logic [1:0] wb_unit;
  logic [3:0] wb_dst;

  sb_issue_ctrl i_sb_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_ready(in_ready), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_c [256];
  int log_u [256];
  int log_d [256];
  int wb_n = 0;
  always @(negedge clk)
    if (wb_valid && wb_n < 256) begin
      log_c[wb_n] = cyc;
      log_u[wb_n] = int'(wb_unit);
      log_d[wb_n] = int'(wb_dst);
      wb_n = wb_n + 1;
    end

  int checks = 0;
  int fails = 0;

  always @(posedge clk)
    if (cyc == 20000) begin
      $display("FAIL watchdog: run hung, actual cyc=%0d expected below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int a, input int b, input int d,
                       output int pcyc, output int icyc);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'(op);
    in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(d);
    pcyc = cyc;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    icyc = cyc;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk_wb(input int idx, input string req, input int ec, input int eu, input int ed);
    chk(log_c[idx] == ec, req, log_c[idx], ec);
    chk(log_u[idx] == eu, req, log_u[idx], eu);
    chk(log_d[idx] == ed, req, log_d[idx], ed);
  endtask

  localparam int NV = 6;
  localparam int V_OP  [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int V_A   [NV] = '{1, 2, 3, 4, 12, 0};
  localparam int V_B   [NV] = '{2, 3, 4, 5, 12, 1};
  localparam int V_D   [NV] = '{6, 7, 8, 9, 12, 15};
  localparam int V_LAT [NV] = '{2, 2, 4, 8, 2, 4};
  localparam int V_U   [NV] = '{0, 0, 1, 2, 0, 1};

  initial begin
    int p, c, c1, c2, c3, c4, s;

    repeat (3) @(negedge clk);
    chk(wb_valid == 1'b0, "R10 wb idle in reset", int'(wb_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R1 no ready without valid", int'(in_ready), 0);
    chk(wb_valid == 1'b0, "R10 wb idle after reset", int'(wb_valid), 0);
    in_valid = 1'b1; in_op = 2'd3; in_src_a = 4'd0; in_src_b = 4'd1; in_dst = 4'd2;
    #1;
    chk(in_ready == 1'b1, "R10 fresh instruction accepted", int'(in_ready), 1);
    in_valid = 1'b0;
    idle(2);

    // R2 and R5: isolated instructions walked from a table
    for (int r = 0; r < NV; r++) begin
      s = wb_n;
      issue(V_OP[r], V_A[r], V_B[r], V_D[r], p, c);
      idle(20);
      chk(wb_n - s == 1, "R5 one write-back per instruction", wb_n - s, 1);
      chk_wb(s, "R2 R5 table row", c + V_LAT[r], V_U[r], V_D[r]);
    end

    // R3 R4: read after write on first source
    s = wb_n;
    issue(2, 0, 0, 3, p, c1);
    issue(0, 3, 4, 6, p, c2);
    idle(20);
    chk(c2 == c1 + 5, "R4 dependent issues after write-back", c2 - c1, 5);
    chk_wb(s, "R4 producer wb", c1 + 4, 1, 3);

    // R3: second source reserved
    issue(0, 1, 1, 7, p, c1);
    issue(2, 8, 7, 9, p, c2);
    idle(20);
    chk(c2 == c1 + 3, "R3 second source hazard", c2 - c1, 3);

    // R3: write after write on destination
    issue(3, 1, 2, 5, p, c1);
    issue(0, 1, 2, 5, p, c2);
    idle(20);
    chk(c2 == c1 + 9, "R3 destination hazard", c2 - c1, 9);

    // R6: pipelined back to back
    s = wb_n;
    issue(0, 0, 1, 2, p, c1);
    issue(1, 0, 1, 3, p, c2);
    issue(2, 0, 1, 4, p, c3);
    issue(2, 0, 1, 5, p, c4);
    idle(20);
    chk(c2 == c1 + 1, "R6 add accepts every cycle", c2 - c1, 1);
    chk(c4 == c3 + 1, "R6 mul accepts every cycle", c4 - c3, 1);
    chk_wb(s + 1, "R6 second add wb", c2 + 2, 0, 3);
    chk_wb(s + 3, "R6 second mul wb", c4 + 4, 1, 5);

    // R7: divider not pipelined
    s = wb_n;
    issue(3, 0, 0, 1, p, c1);
    issue(3, 0, 0, 2, p, c2);
    idle(25);
    chk(c2 == c1 + 9, "R7 second divide waits", c2 - c1, 9);
    chk_wb(s + 1, "R7 second divide wb", c2 + 8, 2, 2);

    // R8 R9: mul versus adds at the port
    s = wb_n;
    issue(2, 0, 0, 1, p, c);
    idle(1);
    issue(0, 0, 0, 2, p, c1);
    issue(0, 0, 0, 3, p, c2);
    issue(0, 0, 0, 4, p, c3);
    idle(20);
    chk(c1 == c + 2 && c2 == c + 3, "R6 adds issue freely", c2 - c, 3);
    chk(c3 == c + 5, "R9 stalled adder refuses", c3 - c, 5);
    chk_wb(s, "R8 older mul wins", c + 4, 1, 1);
    chk_wb(s + 1, "R8 first add delayed", c + 5, 0, 2);
    chk_wb(s + 2, "R8 second add delayed", c + 6, 0, 3);
    chk_wb(s + 3, "R8 third add", c + 7, 0, 4);

    // R8: three-way collision
    s = wb_n;
    issue(3, 0, 0, 10, p, c);
    idle(3);
    issue(2, 0, 0, 11, p, c1);
    idle(1);
    issue(1, 0, 0, 12, p, c2);
    idle(20);
    chk(c1 == c + 4 && c2 == c + 6, "R8 setup issue cycles", c2 - c, 6);
    chk(wb_n - s == 3, "R8 three write-backs", wb_n - s, 3);
    chk_wb(s, "R8 divide oldest", c + 8, 2, 10);
    chk_wb(s + 1, "R8 mul second", c + 9, 1, 11);
    chk_wb(s + 2, "R8 add last", c + 10, 0, 12);

    // R1: held instruction not issued while valid low
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R1 idle no ready", int'(in_ready), 0);

    // R10: reset discards in-flight work and reservations
    s = wb_n;
    issue(3, 0, 0, 13, p, c);
    idle(2);
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    issue(0, 13, 13, 13, p, c1);
    idle(20);
    chk(c1 == p, "R10 no stale reservation", c1 - p, 0);
    chk(wb_n - s == 1, "R10 lost divide never writes", wb_n - s, 1);
    chk(log_u[s] == 0, "R10 only the add writes back", log_u[s], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule